// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Write Slave

This block accepts byte writes from a small microcontroller's external data bus and stores them in one register inside the FPGA. The bus shares one 8-bit port between the low address byte and the data byte, and carries the high address byte on a second port. An address-latch-enable strobe marks the address phase, and an active-low write strobe marks the data phase.

The block passes every bus pin through a two-flop synchronizer into its own system clock and finds strobe edges on the synchronized copies. The low address byte is held when the latch-enable strobe falls. It is then placed under the high address byte to form a 16-bit address. When the write strobe returns high and that address equals the decode value 0x0709, the data byte is stored in the register. A one-cycle pulse marks each update. Software on the microcontroller writes a byte to external address 0x0709, and FPGA logic reads the register and the pulse.

Top module: `mcu_wr_slave`

## Requirements
- R1: While reset is asserted, and right after it is released, data_o is 0x00 and wr_valid_o is 0.
- R2: The low address byte is the value bus_ad_i held while bus_ale_i was still high. bus_ad_i may change in the same cycle that bus_ale_i falls without changing the captured byte.
- R3: After a write strobe that ends while the address {bus_ah_i, latched low byte} equals 0x0709, data_o holds the data byte that was on bus_ad_i while bus_wr_ni was low.
- R4: The register is committed only when bus_wr_ni returns high. While bus_wr_ni stays low, data_o and wr_valid_o do not change.
- R5: A write strobe whose address differs from 0x0709, in either the high byte or the low byte, leaves data_o unchanged and raises no pulse.
- R6: Each accepted write raises wr_valid_o for exactly one clock, in the same cycle that data_o takes its new value. data_o changes in no other cycle.
- R7: A write strobe with no latch-enable phase before it uses the most recently captured low address byte.
- R8: The data byte is the value sampled before the write strobe rises. bus_ad_i changing in the same cycle that bus_wr_ni rises does not change the stored byte.
- R9: An accepted write updates the outputs on the third rising clock edge after the first edge at which bus_wr_ni is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_ad_i | input | 8 | Multiplexed low address / data port |
| bus_ah_i | input | 8 | High address port |
| bus_wr_ni | input | 1 | Write strobe, active low |
| bus_ale_i | input | 1 | Address latch enable, active high |
| data_o | output | 8 | Stored register value |
| wr_valid_o | output | 1 | One-cycle pulse on register update |

## Verification
Writes to 0x0709 with different data bytes show that data is captured and that each write raises one pulse. Writes that miss only in the high byte or only in the low byte show that both halves of the address are decoded. A long write strobe, with a check taken while it is still low, separates commit-at-end from commit-at-start. In every cycle the port changes in the same cycle as the falling latch-enable strobe or the rising write strobe, so a design that samples too late captures the wrong byte. Writes with no latch-enable phase show that the held low byte is reused, both for a hit and for a miss.

// File: rtl/mcu_wr_pkg.sv
package mcu_wr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2 * BYTE_W;

  // strobe pair carried through one synchronizer
  typedef struct packed {
    logic wr_n;
    logic ale;
  } strobe_t;

  // address/data pair carried through the data-path synchronizer
  typedef struct packed {
    logic [BYTE_W-1:0] ah;
    logic [BYTE_W-1:0] ad;
  } port_t;

  localparam strobe_t STROBE_IDLE = '{wr_n: 1'b1, ale: 1'b0};
  localparam port_t   PORT_IDLE   = '{ah: '0, ad: '0};
endpackage

// File: rtl/mcu_bus_sync.sv
module mcu_bus_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mcu_strobe_edge.sv
module mcu_strobe_edge
  import mcu_wr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t strb_i,
  output logic    ale_fall_o,
  output logic    wr_rise_o
);
  strobe_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= STROBE_IDLE;
    else         prev_q <= strb_i;
  end

  assign ale_fall_o = prev_q.ale & ~strb_i.ale;
  assign wr_rise_o  = ~prev_q.wr_n & strb_i.wr_n;
endmodule

// File: rtl/mcu_addr_latch.sv
module mcu_addr_latch
  import mcu_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_fall_i,
  input  logic [BYTE_W-1:0] ad_i,
  output logic [BYTE_W-1:0] lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lo_o <= '0;
    else if (ale_fall_i) lo_o <= ad_i;
  end
endmodule

// File: rtl/mcu_wr_capture.sv
module mcu_wr_capture
  import mcu_wr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MATCH_ADDR = 16'h0709
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              vld_o
);
  logic hit;

  assign hit = wr_rise_i && (addr_i == MATCH_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= hit;
      if (hit) data_o <= data_i;
    end
  end
endmodule

// File: rtl/mcu_wr_slave.sv
module mcu_wr_slave
  import mcu_wr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MATCH_ADDR  = 16'h0709,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] bus_ad_i,
  input  logic [BYTE_W-1:0] bus_ah_i,
  input  logic              bus_wr_ni,
  input  logic              bus_ale_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              wr_valid_o
);
  // port path gets one extra stage so it lines up with the edge detector's previous sample
  localparam int unsigned PORT_STAGES = SYNC_STAGES + 1;

  strobe_t           strb_raw, strb_s;
  port_t             port_raw, port_s;
  logic              ale_fall, wr_rise;
  logic [BYTE_W-1:0] lo_addr;
  logic [ADDR_W-1:0] addr_full;

  assign strb_raw = '{wr_n: bus_wr_ni, ale: bus_ale_i};
  assign port_raw = '{ah: bus_ah_i, ad: bus_ad_i};

  mcu_bus_sync #(
    .W($bits(strobe_t)), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)
  ) u_strb_sync (
    .clk_i, .rst_ni, .d_i(strb_raw), .q_o(strb_s)
  );

  mcu_bus_sync #(
    .W($bits(port_t)), .STAGES(PORT_STAGES), .RST_VAL(PORT_IDLE)
  ) u_port_sync (
    .clk_i, .rst_ni, .d_i(port_raw), .q_o(port_s)
  );

  mcu_strobe_edge u_edge (
    .clk_i, .rst_ni, .strb_i(strb_s), .ale_fall_o(ale_fall), .wr_rise_o(wr_rise)
  );

  mcu_addr_latch u_lo (
    .clk_i, .rst_ni, .ale_fall_i(ale_fall), .ad_i(port_s.ad), .lo_o(lo_addr)
  );

  assign addr_full = {port_s.ah, lo_addr};

  mcu_wr_capture #(.MATCH_ADDR(MATCH_ADDR)) u_cap (
    .clk_i, .rst_ni, .wr_rise_i(wr_rise), .addr_i(addr_full), .data_i(port_s.ad),
    .data_o, .vld_o(wr_valid_o)
  );
endmodule

// File: rtl/mcu_wr_slave_chk.sv
module mcu_wr_slave_chk
  import mcu_wr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MATCH_ADDR = 16'h0709
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] data_o,
  input logic              wr_valid_o,
  input logic              wr_rise,
  input logic              ale_fall,
  input logic [BYTE_W-1:0] lo_addr,
  input logic [ADDR_W-1:0] addr_full
);
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r6_change_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> wr_valid_o);

  a_r4_pulse_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(wr_rise));

  a_r5_pulse_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($past(addr_full) == MATCH_ADDR));

  a_r2_lo_moves_on_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lo_addr) |-> $past(ale_fall));
endmodule

bind mcu_wr_slave mcu_wr_slave_chk #(.MATCH_ADDR(MATCH_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_o(data_o), .wr_valid_o(wr_valid_o),
  .wr_rise(wr_rise), .ale_fall(ale_fall), .lo_addr(lo_addr), .addr_full(addr_full)
);

// File: tb/mcu_wr_slave_tb.sv
module mcu_wr_slave_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ad = 8'h00, ah = 8'h00;
  logic       wr_n = 1'b1, ale = 1'b0;
  logic [7:0] data_o;
  logic       wr_valid_o;

  int checks = 0, errors = 0, pulse_cnt = 0;
  bit run_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_wr_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_ad_i(ad), .bus_ah_i(ah),
    .bus_wr_ni(wr_n), .bus_ale_i(ale), .data_o(data_o), .wr_valid_o(wr_valid_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model: history of input samples, newest first
  logic [17:0] hist[$];
  logic [7:0]  m_lo, m_data;
  logic        m_vld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      repeat (4) hist.push_front({8'h00, 8'h00, 1'b1, 1'b0});
      m_lo = 0; m_data = 0; m_vld = 0;
    end else begin
      logic [17:0] cur, prv;
      hist.push_front({ah, ad, wr_n, ale});
      if (hist.size() > 8) void'(hist.pop_back());
      cur = hist[2];
      prv = hist[3];
      m_vld = 1'b0;
      if (!prv[1] && cur[1] && ({prv[17:10], m_lo} == 16'h0709)) begin
        m_vld  = 1'b1;
        m_data = prv[9:2];
      end
      if (prv[0] && !cur[0]) m_lo = prv[9:2];
    end
  end

  always @(negedge clk) begin
    if (wr_valid_o === 1'b1) pulse_cnt++;
    if (run_cmp) begin
      check("R3 cycle data", data_o, m_data);
      check("R6 cycle pulse", {7'b0, wr_valid_o}, {7'b0, m_vld});
    end
  end

  // address phase then data phase; port flips at each strobe edge (R2, R8)
  task automatic bus_write(logic [7:0] a_hi, logic [7:0] a_lo, logic [7:0] d,
                           int hold, bit mid_chk);
    logic [7:0] old_d;
    int old_p;
    @(negedge clk); ah = a_hi; ad = 8'h5C; ale = 1'b1;
    @(negedge clk); ad = a_lo;
    repeat (2) @(negedge clk);
    ale = 1'b0; ad = d;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    if (mid_chk) begin
      old_d = data_o; old_p = pulse_cnt;
      repeat (hold - 1) @(negedge clk);
      #1;
      check("R4 no commit while low", data_o, old_d);
      check("R4 no pulse while low", 8'(pulse_cnt), 8'(old_p));
      @(negedge clk);
    end else repeat (hold) @(negedge clk);
    wr_n = 1'b1; ad = ~d;
    repeat (6) @(negedge clk);
    ad = 8'hEE;
  endtask

  task automatic write_no_ale(logic [7:0] a_hi, logic [7:0] d);
    @(negedge clk); ah = a_hi; ad = d;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; ad = ~d;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check("R1 data in reset", data_o, 8'h00);
    check("R1 pulse in reset", {7'b0, wr_valid_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 data after reset", data_o, 8'h00);
    run_cmp = 1'b1;

    p0 = pulse_cnt;
    bus_write(8'h07, 8'h09, 8'hA5, 3, 1'b0);
    check("R3 R2 R8 hit stores byte", data_o, 8'hA5);
    check("R6 one pulse per write", 8'(pulse_cnt - p0), 8'd1);

    p0 = pulse_cnt;
    bus_write(8'h08, 8'h09, 8'h11, 3, 1'b0);
    check("R5 high byte miss data", data_o, 8'hA5);
    check("R5 high byte miss pulse", 8'(pulse_cnt - p0), 8'd0);

    bus_write(8'h07, 8'h08, 8'h22, 3, 1'b0);
    check("R5 low byte miss data", data_o, 8'hA5);
    check("R5 low byte miss pulse", 8'(pulse_cnt - p0), 8'd0);

    p0 = pulse_cnt;
    bus_write(8'h07, 8'h09, 8'h3C, 12, 1'b1);
    check("R4 commit at strobe end", data_o, 8'h3C);
    check("R6 long strobe one pulse", 8'(pulse_cnt - p0), 8'd1);

    // R9: outputs change on the third rising edge after wr_n first sampled high
    @(negedge clk); ah = 8'h07; ad = 8'h09; ale = 1'b1;
    repeat (2) @(negedge clk); ale = 1'b0; ad = 8'h6B;
    repeat (2) @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1; ad = 8'h00;
    @(negedge clk); #1;
    check("R9 not yet after 1 edge", data_o, 8'h3C);
    @(negedge clk); #1;
    check("R9 not yet after 2 edges", data_o, 8'h3C);
    @(negedge clk); #1;
    check("R9 data after 3 edges", data_o, 8'h6B);
    check("R9 pulse after 3 edges", {7'b0, wr_valid_o}, 8'h01);
    repeat (4) @(negedge clk);

    p0 = pulse_cnt;
    write_no_ale(8'h07, 8'hC3);
    check("R7 reused low byte hit", data_o, 8'hC3);
    check("R7 reused low byte pulse", 8'(pulse_cnt - p0), 8'd1);

    bus_write(8'h07, 8'h10, 8'h77, 3, 1'b0);
    p0 = pulse_cnt;
    write_no_ale(8'h07, 8'h88);
    check("R7 reused low byte miss", data_o, 8'hC3);
    check("R7 reused miss pulse", 8'(pulse_cnt - p0), 8'd0);

    bus_write(8'h07, 8'h09, 8'h00, 2, 1'b0);
    check("R3 zero data", data_o, 8'h00);
    bus_write(8'h07, 8'h09, 8'hFF, 2, 1'b0);
    check("R3 all-ones data", data_o, 8'hFF);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule